// File: doc/BRIEF.md
# Condition Field Compare Unit

This block compares two 32-bit values and returns a 4-bit condition field that reports whether the first value is below, above or equal to the second. The second value is either a register operand or a 16-bit immediate. The immediate is sign-extended for signed compares and zero-extended for unsigned compares. A record mode compares a single result against zero as a signed value. A separate flag-move operation packs the summary-overflow, overflow and carry flags into a field of the same shape.

A request is presented for one cycle with an operation code, the operands, the immediate and the current flag bits. The field appears in a register on the next clock edge, together with a one-cycle valid strobe. The field keeps its value until the next accepted request.

Top module: `cond_field_unit`

## Requirements
- R1: While reset (active low) is held, and on release, `field_out` is 0 and `valid_out` is 0.
- R2: A request with a supported operation code (0 to 5) raises `valid_out` for exactly the one cycle after the request edge. Without a request, `valid_out` is 0.
- R3: Operation code 0 compares `opa` with `opb` as signed values. Less-than is tested first, then greater-than, and equal is the remaining case. The relation is encoded in field bits 3 (less, 0x8), 2 (greater, 0x4) and 1 (equal, 0x2).
- R4: Operation code 1 compares `opa` as a signed value with `imm` sign-extended to 32 bits.
- R5: Operation code 2 compares `opa` with `opb` as unsigned values.
- R6: Operation code 3 compares `opa` as an unsigned value with `imm` zero-extended to 32 bits.
- R7: Operation code 4 compares `opa` as a signed value against zero.
- R8: In every compare mode (codes 0 to 4), field bit 0 equals the `so_in` presented with the request.
- R9: Operation code 5 produces `so_in` in bit 3, `ov_in` in bit 2, `ca_in` in bit 1 and 0 in bit 0.
- R10: In every compare result, exactly one of bits 3, 2 and 1 is set.
- R11: A request with a reserved operation code (6 or 7) raises no strobe and leaves `field_out` unchanged.
- R12: Between accepted requests, `field_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, sampled on the clock edge |
| op_sel | input | 3 | Operation code (0 to 5 supported) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate operand |
| so_in | input | 1 | Current summary-overflow flag |
| ov_in | input | 1 | Current overflow flag |
| ca_in | input | 1 | Current carry flag |
| field_out | output | 4 | Registered condition field |
| valid_out | output | 1 | One-cycle result strobe |

## Verification
The unit holds only two registers, the field and the strobe, so a wrong internal state shows at the ports on the first cycle after the request that caused it. A wrong extension of the immediate or a wrong signedness choice appears as a wrong relation bit. Operand pairs are chosen so that signed and unsigned orderings disagree, and so that sign- and zero-extension of the immediate give opposite answers. A field register that is corrupted between requests shows as a change in `field_out` while the strobe is low. A reserved code that is wrongly accepted shows as a strobe or as a changed field.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
   typedef enum logic [2:0] {
      OP_CMP_S   = 3'd0,
      OP_CMP_SI  = 3'd1,
      OP_CMP_U   = 3'd2,
      OP_CMP_UI  = 3'd3,
      OP_ZERO    = 3'd4,
      OP_FLAGS   = 3'd5
   } cfc_op_e;

   localparam int FIELD_W = 4;
   localparam int LT_POS  = 3;
   localparam int GT_POS  = 2;
   localparam int EQ_POS  = 1;
   localparam int SO_POS  = 0;

   localparam int STYLE_SUBTRACT = 0;
   localparam int STYLE_RELATION = 1;
endpackage

// File: rtl/cfc_operand_sel.sv
module cfc_operand_sel
   import cfc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_b,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] lhs,
   output logic [DATA_W-1:0] rhs,
   output logic              signed_cmp,
   output logic              known_op,
   output logic              flag_op
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_sext;
   logic [DATA_W-1:0] imm_zext;

   generate
      if (EXT_W < 1) begin : g_bad_width
         $error("cfc_operand_sel: DATA_W must exceed IMM_W");
      end
   endgenerate

   assign imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign imm_zext = {{EXT_W{1'b0}}, imm};

   always_comb begin
      lhs        = reg_a;
      rhs        = reg_b;
      signed_cmp = 1'b0;
      known_op   = 1'b1;
      flag_op    = 1'b0;
      case (cfc_op_e'(op))
         OP_CMP_S:  begin signed_cmp = 1'b1; end
         OP_CMP_SI: begin signed_cmp = 1'b1; rhs = imm_sext; end
         OP_CMP_U:  begin signed_cmp = 1'b0; end
         OP_CMP_UI: begin signed_cmp = 1'b0; rhs = imm_zext; end
         OP_ZERO:   begin signed_cmp = 1'b1; rhs = '0; end
         OP_FLAGS:  begin flag_op = 1'b1; end
         default:   begin known_op = 1'b0; end
      endcase
   end
endmodule

// File: rtl/cfc_magnitude.sv
module cfc_magnitude
   import cfc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CMP_STYLE = STYLE_SUBTRACT
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              signed_cmp,
   output logic              below,
   output logic              above
);
   localparam int DIFF_W = DATA_W + 2;

   generate
      if (CMP_STYLE == STYLE_SUBTRACT) begin : g_sub
         logic [DIFF_W-1:0] a_ext;
         logic [DIFF_W-1:0] b_ext;
         logic [DIFF_W-1:0] diff;
         logic              a_fill;
         logic              b_fill;
         assign a_fill = signed_cmp & a[DATA_W-1];
         assign b_fill = signed_cmp & b[DATA_W-1];
         assign a_ext  = {a_fill, a_fill, a};
         assign b_ext  = {b_fill, b_fill, b};
         assign diff   = a_ext - b_ext;
         assign below  = diff[DIFF_W-1];
         assign above  = ~diff[DIFF_W-1] & (diff != '0);
      end else if (CMP_STYLE == STYLE_RELATION) begin : g_rel
         always_comb begin
            if (signed_cmp) begin
               below = $signed(a) < $signed(b);
               above = $signed(a) > $signed(b);
            end else begin
               below = a < b;
               above = a > b;
            end
         end
      end else begin : g_bad_style
         $error("cfc_magnitude: unknown CMP_STYLE");
      end
   endgenerate

   always_comb begin
      AST_LT_GT_EXCLUSIVE: assert (!(below && above) || $isunknown({a, b})); // R10
   end
endmodule

// File: rtl/cfc_field_pack.sv
module cfc_field_pack
   import cfc_pkg::*;
(
   input  logic               below,
   input  logic               above,
   input  logic               flag_op,
   input  logic               so,
   input  logic               ov,
   input  logic               ca,
   output logic [FIELD_W-1:0] field
);
   always_comb begin
      field = '0;
      if (flag_op) begin
         field[LT_POS] = so;
         field[GT_POS] = ov;
         field[EQ_POS] = ca;
         field[SO_POS] = 1'b0;
      end else begin
         if (below) begin
            field[LT_POS] = 1'b1;
         end else if (above) begin
            field[GT_POS] = 1'b1;
         end else begin
            field[EQ_POS] = 1'b1;
         end
         field[SO_POS] = so;
      end
   end
endmodule

// File: rtl/cond_field_unit.sv
module cond_field_unit
   import cfc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 16,
   parameter int CMP_STYLE = STYLE_SUBTRACT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [IMM_W-1:0]  imm,
   input  logic              so_in,
   input  logic              ov_in,
   input  logic              ca_in,
   output logic [3:0]        field_out,
   output logic              valid_out
);
   generate
      if (FIELD_W != 4) begin : g_bad_field
         $error("cond_field_unit: field width must be 4");
      end
   endgenerate

   logic [DATA_W-1:0]  lhs;
   logic [DATA_W-1:0]  rhs;
   logic               signed_cmp;
   logic               known_op;
   logic               flag_op;
   logic               below;
   logic               above;
   logic [FIELD_W-1:0] field_next;
   logic               accept;

   cfc_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
      .op(op_sel), .reg_a(opa), .reg_b(opb), .imm(imm),
      .lhs(lhs), .rhs(rhs), .signed_cmp(signed_cmp),
      .known_op(known_op), .flag_op(flag_op)
   );

   cfc_magnitude #(.DATA_W(DATA_W), .CMP_STYLE(CMP_STYLE)) u_mag (
      .a(lhs), .b(rhs), .signed_cmp(signed_cmp),
      .below(below), .above(above)
   );

   cfc_field_pack u_pack (
      .below(below), .above(above), .flag_op(flag_op),
      .so(so_in), .ov(ov_in), .ca(ca_in), .field(field_next)
   );

   assign accept = req & known_op;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_out <= '0;
         valid_out <= 1'b0;
      end else begin
         valid_out <= accept;
         if (accept) begin
            field_out <= field_next;
         end
      end
   end

   AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out |-> $past(req)); // R2
   AST_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && $past(op_sel) != 3'd5) |-> $countones(field_out[3:1]) == 1); // R10
   AST_STICKY_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && $past(op_sel) != 3'd5) |-> field_out[0] == $past(so_in)); // R8
   AST_FLAG_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && $past(op_sel) == 3'd5) |->
         field_out == {$past(so_in), $past(ov_in), $past(ca_in), 1'b0}); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_out |-> $stable(field_out)); // R12
endmodule

// File: tb/cond_field_unit_tb.sv
module cond_field_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req;
   logic [2:0]  op_sel;
   logic [31:0] opa;
   logic [31:0] opb;
   logic [15:0] imm;
   logic        so_in, ov_in, ca_in;
   logic [3:0]  field_out;
   logic        valid_out;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   cond_field_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .op_sel(op_sel),
      .opa(opa), .opb(opb), .imm(imm),
      .so_in(so_in), .ov_in(ov_in), .ca_in(ca_in),
      .field_out(field_out), .valid_out(valid_out)
   );

   task automatic check(input string tag, input logic [3:0] got_f, input logic got_v,
                        input logic [3:0] exp_f, input logic exp_v);
      total++;
      if (got_f !== exp_f || got_v !== exp_v) begin
         bad++;
         $display("FAIL %s: field=%h valid=%b expected field=%h valid=%b",
                  tag, got_f, got_v, exp_f, exp_v);
      end
   endtask

   // Drive one request, sample after the edge that registers it, then go idle.
   task automatic issue(input string tag, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] im,
                        input logic so, input logic ov, input logic ca,
                        input logic [3:0] exp_f, input logic exp_v);
      @(negedge clk);
      req = 1'b1; op_sel = op; opa = a; opb = b; imm = im;
      so_in = so; ov_in = ov; ca_in = ca;
      @(posedge clk); #1;
      check(tag, field_out, valid_out, exp_f, exp_v);
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0; req = 1'b0; op_sel = '0; opa = '0; opb = '0; imm = '0;
      so_in = 1'b0; ov_in = 1'b0; ca_in = 1'b0;
      repeat (3) @(posedge clk);
      #1 check("R1 during reset", field_out, valid_out, 4'h0, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1 check("R1 after release", field_out, valid_out, 4'h0, 1'b0);
   endtask

   task automatic t_signed_reg;
      issue("R3 signed less", 3'd0, 32'hFFFF_FFFB, 32'd3, 16'h0, 0, 0, 0, 4'h8, 1);
      issue("R3 signed greater", 3'd0, 32'd7, 32'hFFFF_FFFF, 16'h0, 0, 0, 0, 4'h4, 1);
      issue("R3 R8 signed equal with so", 3'd0, 32'h1234_5678, 32'h1234_5678, 16'h0,
            1, 0, 0, 4'h3, 1);
      issue("R3 signed min vs max", 3'd0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0,
            0, 0, 0, 4'h8, 1);
   endtask

   task automatic t_signed_imm;
      issue("R4 sext imm less", 3'd1, 32'hFFFF_FFFE, 32'd0, 16'hFFFF, 0, 0, 0, 4'h8, 1);
      issue("R4 sext imm greater", 3'd1, 32'h0000_FFFF, 32'd0, 16'hFFFF, 0, 0, 0, 4'h4, 1);
      issue("R4 sext imm equal", 3'd1, 32'hFFFF_8000, 32'd5, 16'h8000, 1, 1, 1, 4'h3, 1);
   endtask

   task automatic t_uns_reg;
      issue("R5 unsigned greater", 3'd2, 32'hFFFF_FFFB, 32'd3, 16'h0, 0, 0, 0, 4'h4, 1);
      issue("R5 unsigned less", 3'd2, 32'd1, 32'd2, 16'h0, 0, 0, 0, 4'h8, 1);
      issue("R5 R8 unsigned equal so", 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0,
            1, 0, 0, 4'h3, 1);
   endtask

   task automatic t_uns_imm;
      issue("R6 zext imm equal", 3'd3, 32'h0000_FFFF, 32'd0, 16'hFFFF, 0, 0, 0, 4'h2, 1);
      issue("R6 zext imm greater", 3'd3, 32'hFFFF_FFFE, 32'd0, 16'hFFFF, 0, 0, 0, 4'h4, 1);
      issue("R6 zext imm less", 3'd3, 32'd5, 32'hFFFF_FFFF, 16'h8000, 0, 0, 0, 4'h8, 1);
   endtask

   task automatic t_zero_rec;
      issue("R7 zero equal", 3'd4, 32'd0, 32'd9, 16'h0, 0, 0, 0, 4'h2, 1);
      issue("R7 zero negative", 3'd4, 32'h8000_0000, 32'd0, 16'h0, 0, 0, 0, 4'h8, 1);
      issue("R7 zero positive", 3'd4, 32'd1, 32'hFFFF_FFFF, 16'h0, 0, 0, 0, 4'h4, 1);
      issue("R7 R8 zero positive so", 3'd4, 32'd5, 32'd0, 16'h0, 1, 1, 1, 4'h5, 1);
   endtask

   task automatic t_flag_move;
      issue("R9 flags so ca", 3'd5, 32'd0, 32'd0, 16'h0, 1, 0, 1, 4'hA, 1);
      issue("R9 flags ov", 3'd5, 32'd0, 32'd0, 16'h0, 0, 1, 0, 4'h4, 1);
      issue("R9 flags all", 3'd5, 32'd0, 32'd0, 16'h0, 1, 1, 1, 4'hE, 1);
   endtask

   task automatic t_reserved;
      issue("R2 setup equal", 3'd2, 32'd4, 32'd4, 16'h0, 0, 0, 0, 4'h2, 1);
      issue("R11 code 6 ignored", 3'd6, 32'd1, 32'd2, 16'h0, 1, 1, 1, 4'h2, 0);
      issue("R11 code 7 ignored", 3'd7, 32'd9, 32'd2, 16'h0, 1, 1, 1, 4'h2, 0);
   endtask

   task automatic t_hold;
      issue("R10 single relation", 3'd0, 32'd2, 32'd9, 16'h0, 0, 0, 0, 4'h8, 1);
      @(posedge clk); #1 check("R2 R12 idle cycle one", field_out, valid_out, 4'h8, 1'b0);
      @(negedge clk);
      opa = 32'hFFFF_FFFF; op_sel = 3'd4; so_in = 1'b1;
      @(posedge clk); #1 check("R12 idle inputs move", field_out, valid_out, 4'h8, 1'b0);
   endtask

   initial begin : watchdog
      #500_000;
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_signed_reg();
      t_signed_imm();
      t_uns_reg();
      t_uns_imm();
      t_zero_rec();
      t_flag_move();
      t_reserved();
      t_hold();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule